// File: doc/BRIEF.md
# Register bank with partial-write error reporting

This block is a memory-mapped register slave for a 32-bit bus with four byte-enable lines, one per data byte. It holds a small set of internal registers that take byte-masked writes. It forwards accesses for a set of external registers to per-register port pins: an enable, a write valid, shared write data, a read valid and read data. It also presents status words that are not stored in the block and are read directly from hardware inputs.

External registers and status words must always be written a whole word at a time. Any write to them that leaves a byte lane disabled raises a bus error in the same cycle as the write strobe. A write to an external register is still passed to its port when it raises the error. The byte-access error is ORed with an error input from outside logic to form the bus error. Read data is the OR of the block's own read data and whatever the external logic returns with its read valid.

Word decode uses address bits [ADDR_W-1:2]. A build parameter selects unaligned decode: when it is on, the two low address bits are ignored and an access starting inside a word reaches that word's register, with the byte enables naming the lanes involved. When it is off, an access whose two low address bits are not zero selects nothing.

Top module: `lane_guard_regs`

## Requirements
- R1: After reset every internal register reads as zero.
- R2: A write to an internal register updates only the bytes whose enable bit is set (bit b covers data bits 8b+7 to 8b) and never raises the bus error.
- R3: A write to an external register with all four byte enables set asserts that register's write valid and enable, drives the bus write data onto the shared write-data output, and raises no error.
- R4: A write to an external register with any byte enable clear raises the bus error in the same cycle and is still forwarded with write valid and enable asserted.
- R5: A write to a status word with any byte enable clear raises the bus error; a full write raises no error and has no effect, since reads keep returning the hardware input.
- R6: Reads never raise the byte-access error, whatever the byte enables.
- R7: The external error input passes to the bus error in any cycle, whether or not an access is in progress.
- R8: Bus read data is the OR of the selected internal register or status word (zero when nothing internal is read) and the read data of every external register whose read valid is high.
- R9: Word index addr[ADDR_W-1:2] maps 0 to N_INT-1 to internal registers, the next N_EXT words to external registers and the next N_STAT words to status words; any other word selects nothing, reads zero internal data and raises no byte-access error.
- R10: With unaligned decode on, the two low address bits are ignored; with it off, an access with nonzero low address bits selects no register and writes nothing.
- R11: An external register's enable is high on a read or write to it; its write valid is high only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit b for lane b |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Bus error, same cycle as the strobe |
| ext_enb | output | N_EXT | Per external register access enable |
| ext_wr_valid | output | N_EXT | Per external register write valid |
| ext_wdata | output | 32 | Write data to external registers |
| ext_rd_valid | input | N_EXT | Read valid from external logic |
| ext_rd_data | input | N_EXT x 32 | Read data from external logic |
| hw_stat | input | N_STAT x 32 | Hardware values of the status words |
| ext_err_in | input | 1 | Error from external logic |

## Verification
The bench goes after single-lane and mixed-lane writes to internal registers, where a design that decoded the enables wrongly would corrupt neighbouring bytes or flag a spurious error. It writes external registers and status words with partial enables, where a design that suppressed the forwarded write, or missed the check on status words, would show up at the ports, and it reads with partial enables to catch a check that ignores the direction. It issues accesses with nonzero low address bits to two instances built with unaligned decode on and off, where a wrong decode would hit the wrong register or write when it should not. It returns external data both with and without read valid to catch an ungated OR.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // True when every byte lane is enabled.
    function automatic logic all_lanes(input lanes_t be);
        return &be;
    endfunction
endpackage

// File: rtl/lgr_decode.sv
module lgr_decode
    import lgr_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int N_INT         = 4,
    parameter int N_EXT         = 2,
    parameter int N_STAT        = 2,
    parameter bit UNALIGNED_DEC = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_INT-1:0]  int_sel,
    output logic [N_EXT-1:0]  ext_sel,
    output logic [N_STAT-1:0] stat_sel
);
    localparam int WIDX_W    = ADDR_W - 2;
    localparam int EXT_BASE  = N_INT;
    localparam int STAT_BASE = N_INT + N_EXT;

    logic [WIDX_W-1:0] widx;
    logic [1:0]        boff;
    logic              aligned_ok;

    assign widx = addr[ADDR_W-1:2];
    assign boff = addr[1:0];

    generate
        if (UNALIGNED_DEC) begin : g_unal
            // low bits only pick lanes, which the byte enables already name
            assign aligned_ok = (boff == boff);
        end else begin : g_strict
            assign aligned_ok = (boff == 2'b00);
        end
    endgenerate

    generate
        for (genvar i = 0; i < N_INT; i++) begin : g_int
            assign int_sel[i] = aligned_ok && (widx == WIDX_W'(i));
        end
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext
            assign ext_sel[i] = aligned_ok && (widx == WIDX_W'(EXT_BASE + i));
        end
        for (genvar i = 0; i < N_STAT; i++) begin : g_stat
            assign stat_sel[i] = aligned_ok && (widx == WIDX_W'(STAT_BASE + i));
        end
    endgenerate
endmodule

// File: rtl/lgr_int_bank.sv
module lgr_int_bank
    import lgr_pkg::*;
#(
    parameter int N_INT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [N_INT-1:0] sel,
    input  word_t            wdata,
    input  lanes_t           be,
    output word_t            rdata
);
    word_t regs [N_INT];

    generate
        for (genvar r = 0; r < N_INT; r++) begin : g_reg
            for (genvar b = 0; b < LANES; b++) begin : g_lane
                logic [7:0] lane_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        lane_q <= '0;
                    end else if (wr && sel[r] && be[b]) begin
                        lane_q <= wdata[8*b +: 8];
                    end
                end
                assign regs[r][8*b +: 8] = lane_q;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int r = 0; r < N_INT; r++) begin
            if (rd && sel[r]) begin
                rdata = rdata | regs[r];
            end
        end
    end
endmodule

// File: rtl/lgr_ext_if.sv
module lgr_ext_if
    import lgr_pkg::*;
#(
    parameter int N_EXT       = 2,
    parameter int N_STAT      = 2,
    parameter bit STAT_ERR_EN = 1'b1
) (
    input  logic                          wr,
    input  logic                          rd,
    input  logic [N_EXT-1:0]              ext_sel,
    input  logic [N_STAT-1:0]             stat_sel,
    input  lanes_t                        be,
    input  word_t                         wdata,
    input  logic [N_STAT-1:0][DATA_W-1:0] hw_stat,
    input  logic [N_EXT-1:0]              ext_rd_valid,
    input  logic [N_EXT-1:0][DATA_W-1:0]  ext_rd_data,
    output logic [N_EXT-1:0]              ext_enb,
    output logic [N_EXT-1:0]              ext_wr_valid,
    output word_t                         ext_wdata,
    output word_t                         stat_rdata,
    output word_t                         ext_rdata,
    output logic                          byte_err
);
    logic [N_EXT-1:0]  ext_perr;
    logic [N_STAT-1:0] stat_perr;
    logic              partial;

    assign partial   = !all_lanes(be);
    assign ext_wdata = wdata;

    generate
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext
            assign ext_enb[i]      = ext_sel[i] && (wr || rd);
            assign ext_wr_valid[i] = ext_sel[i] && wr;
            assign ext_perr[i]     = ext_wr_valid[i] && partial;
        end
        for (genvar s = 0; s < N_STAT; s++) begin : g_stat
            if (STAT_ERR_EN) begin : g_chk
                assign stat_perr[s] = stat_sel[s] && wr && partial;
            end else begin : g_nochk
                assign stat_perr[s] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        ext_rdata = '0;
        for (int i = 0; i < N_EXT; i++) begin
            if (ext_rd_valid[i]) begin
                ext_rdata = ext_rdata | ext_rd_data[i];
            end
        end
    end

    always_comb begin
        stat_rdata = '0;
        for (int s = 0; s < N_STAT; s++) begin
            if (rd && stat_sel[s]) begin
                stat_rdata = stat_rdata | hw_stat[s];
            end
        end
    end

    assign byte_err = (|ext_perr) || (|stat_perr);
endmodule

// File: rtl/lane_guard_regs.sv
module lane_guard_regs
    import lgr_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int N_INT         = 4,
    parameter int N_EXT         = 2,
    parameter int N_STAT        = 2,
    parameter bit UNALIGNED_DEC = 1'b1,
    parameter bit STAT_ERR_EN   = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic [3:0]                    bus_be,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_err,
    output logic [N_EXT-1:0]              ext_enb,
    output logic [N_EXT-1:0]              ext_wr_valid,
    output logic [31:0]                   ext_wdata,
    input  logic [N_EXT-1:0]              ext_rd_valid,
    input  logic [N_EXT-1:0][31:0]        ext_rd_data,
    input  logic [N_STAT-1:0][31:0]       hw_stat,
    input  logic                          ext_err_in
);
    logic [N_INT-1:0]  int_sel;
    logic [N_EXT-1:0]  ext_sel;
    logic [N_STAT-1:0] stat_sel;
    word_t             int_rdata;
    word_t             stat_rdata;
    word_t             ext_rdata;
    logic              byte_err;

    lgr_decode #(
        .ADDR_W        (ADDR_W),
        .N_INT         (N_INT),
        .N_EXT         (N_EXT),
        .N_STAT        (N_STAT),
        .UNALIGNED_DEC (UNALIGNED_DEC)
    ) u_decode (
        .addr     (bus_addr),
        .int_sel  (int_sel),
        .ext_sel  (ext_sel),
        .stat_sel (stat_sel)
    );

    lgr_int_bank #(
        .N_INT (N_INT)
    ) u_int_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .sel   (int_sel),
        .wdata (bus_wdata),
        .be    (bus_be),
        .rdata (int_rdata)
    );

    lgr_ext_if #(
        .N_EXT       (N_EXT),
        .N_STAT      (N_STAT),
        .STAT_ERR_EN (STAT_ERR_EN)
    ) u_ext_if (
        .wr           (bus_wr),
        .rd           (bus_rd),
        .ext_sel      (ext_sel),
        .stat_sel     (stat_sel),
        .be           (bus_be),
        .wdata        (bus_wdata),
        .hw_stat      (hw_stat),
        .ext_rd_valid (ext_rd_valid),
        .ext_rd_data  (ext_rd_data),
        .ext_enb      (ext_enb),
        .ext_wr_valid (ext_wr_valid),
        .ext_wdata    (ext_wdata),
        .stat_rdata   (stat_rdata),
        .ext_rdata    (ext_rdata),
        .byte_err     (byte_err)
    );

    assign bus_rdata = int_rdata | stat_rdata | ext_rdata;
    assign bus_err   = byte_err || ext_err_in;
endmodule

// File: rtl/lgr_checker.sv
module lgr_checker #(
    parameter int N_EXT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [3:0]       bus_be,
    input logic             bus_err,
    input logic             ext_err_in,
    input logic [N_EXT-1:0] ext_enb,
    input logic [N_EXT-1:0] ext_wr_valid
);
    // R4: a forwarded partial write to an external register must flag an error
    assert_partial_ext_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ext_wr_valid) && (bus_be != 4'hF)) |-> bus_err);

    // R6: a read alone never produces the byte-access error
    assert_read_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !ext_err_in) |-> !bus_err);

    // R7: the external error always reaches the bus
    assert_ext_err_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_err_in |-> bus_err);

    // R3: full-lane writes are never flagged
    assert_full_write_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_be == 4'hF) && !ext_err_in) |-> !bus_err);

    // R9: at most one external register is selected
    assert_single_enb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_enb));

    // R11: write valid comes with enable and only on a write
    assert_wv_has_enb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_wr_valid) |-> (bus_wr && ((ext_wr_valid & ~ext_enb) == '0)));

    // R11: no enable without an access
    assert_enb_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_enb) |-> (bus_wr || bus_rd));
endmodule

bind lane_guard_regs lgr_checker #(.N_EXT(N_EXT)) u_lgr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_be       (bus_be),
    .bus_err      (bus_err),
    .ext_err_in   (ext_err_in),
    .ext_enb      (ext_enb),
    .ext_wr_valid (ext_wr_valid)
);

// File: tb/lane_guard_regs_bench.sv
module lane_guard_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, ext_err_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [1:0]  ext_rv = '0;
    logic [1:0][31:0] ext_rdat = '0;
    logic [1:0][31:0] hw = '0;

    logic [31:0] rdata0, rdata1, wd0, wd1;
    logic        err0, err1;
    logic [1:0]  enb0, enb1, wv0, wv1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] mdl [2][4];

    always #4 clk = ~clk;

    lane_guard_regs u_lane_guard_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(rdata0), .bus_err(err0), .ext_enb(enb0), .ext_wr_valid(wv0),
        .ext_wdata(wd0), .ext_rd_valid(ext_rv), .ext_rd_data(ext_rdat),
        .hw_stat(hw), .ext_err_in(ext_err_in));

    lane_guard_regs #(.UNALIGNED_DEC(1'b0)) u_lane_guard_regs_strict (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(rdata1), .bus_err(err1), .ext_enb(enb1), .ext_wr_valid(wv1),
        .ext_wdata(wd1), .ext_rd_valid(ext_rv), .ext_rd_data(ext_rdat),
        .hw_stat(hw), .ext_err_in(ext_err_in));

    task automatic chk(input string tag, input string what, input int m,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s inst%0d: actual %h expected %h", tag, what, m, got, exp);
        end
    endtask

    // One bus cycle, driven at the falling edge and checked before the rising edge.
    task automatic cyc(input string tag, input logic wr, input logic rd,
                       input logic [7:0] addr, input logic [31:0] wd,
                       input logic [3:0] be, input logic ein);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        bus_be = be; ext_err_in = ein;
        #1;
        for (int m = 0; m < 2; m++) begin
            bit hit = (m == 0) || (addr % 4 == 0);
            int w = addr / 4;
            logic [31:0] e_rd = '0;
            logic        e_err = ein;
            logic [1:0]  e_enb = '0, e_wv = '0;
            for (int i = 0; i < 2; i++) if (ext_rv[i]) e_rd |= ext_rdat[i];
            if (hit) begin
                if (w < 4) begin
                    if (rd) e_rd |= mdl[m][w];
                end else if (w < 6) begin
                    if (rd || wr) e_enb[w-4] = 1'b1;
                    if (wr) begin
                        e_wv[w-4] = 1'b1;
                        if (be != 4'hF) e_err = 1'b1;
                    end
                end else if (w < 8) begin
                    if (rd) e_rd |= hw[w-6];
                    if (wr && be != 4'hF) e_err = 1'b1;
                end
            end
            chk(tag, "rdata", m, (m == 0) ? rdata0 : rdata1, e_rd);
            chk(tag, "err", m, {31'b0, (m == 0) ? err0 : err1}, {31'b0, e_err});
            chk(tag, "enb", m, {30'b0, (m == 0) ? enb0 : enb1}, {30'b0, e_enb});
            chk(tag, "wr_valid", m, {30'b0, (m == 0) ? wv0 : wv1}, {30'b0, e_wv});
            if (e_wv != 0) chk(tag, "ext_wdata", m, (m == 0) ? wd0 : wd1, wd);
        end
        @(posedge clk);
        for (int m = 0; m < 2; m++) begin
            bit hit = (m == 0) || (addr % 4 == 0);
            int w = addr / 4;
            if (wr && hit && w < 4)
                for (int b = 0; b < 4; b++)
                    if (be[b]) mdl[m][w][8*b +: 8] = wd[8*b +: 8];
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; ext_err_in = 0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 2; m++) for (int r = 0; r < 4; r++) mdl[m][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: registers empty after reset
        for (int r = 0; r < 4; r++) cyc("R1", 0, 1, 8'(r * 4), '0, 4'hF, 0);
        // R2: full and lane-masked internal writes
        cyc("R2", 1, 0, 8'h00, 32'hA5A5_1234, 4'hF, 0);
        cyc("R2", 0, 1, 8'h00, '0, 4'hF, 0);
        cyc("R2", 1, 0, 8'h04, 32'hFFFF_FFFF, 4'b0101, 0);
        cyc("R2", 0, 1, 8'h04, '0, 4'hF, 0);
        cyc("R2", 1, 0, 8'h04, 32'h1122_3344, 4'b1000, 0);
        cyc("R2", 0, 1, 8'h04, '0, 4'h1, 0);
        cyc("R2", 1, 0, 8'h0C, 32'hDEAD_BEEF, 4'b0110, 0);
        cyc("R2", 0, 1, 8'h0C, '0, 4'hF, 0);
        // R3: full external write
        cyc("R3", 1, 0, 8'h10, 32'h0BAD_F00D, 4'hF, 0);
        // R4: partial external writes, still forwarded
        cyc("R4", 1, 0, 8'h14, 32'h1357_9BDF, 4'b0011, 0);
        cyc("R4", 1, 0, 8'h10, 32'h2468_ACE0, 4'b0000, 0);
        // R6 and R8: read external with partial enables, data returned with valid
        ext_rv = 2'b01; ext_rdat[0] = 32'hCAFE_0001;
        cyc("R6", 0, 1, 8'h10, '0, 4'b0001, 0);
        // R8: external data without valid is not merged
        ext_rv = 2'b00; ext_rdat[1] = 32'hFFFF_0000;
        cyc("R8", 0, 1, 8'h00, '0, 4'hF, 0);
        // R8: valid external data ORed with internal read
        ext_rv = 2'b10;
        cyc("R8", 0, 1, 8'h04, '0, 4'hF, 0);
        ext_rv = 2'b00;
        // R5: status words
        hw[0] = 32'h5A5A_0000; hw[1] = 32'h0000_00C3;
        cyc("R5", 1, 0, 8'h18, 32'hFFFF_FFFF, 4'b1110, 0);
        cyc("R5", 1, 0, 8'h1C, 32'hFFFF_FFFF, 4'hF, 0);
        cyc("R5", 0, 1, 8'h1C, '0, 4'hF, 0);
        cyc("R5", 0, 1, 8'h18, '0, 4'b0100, 0);
        // R7: external error idle and during a read
        cyc("R7", 0, 0, 8'h00, '0, 4'h0, 1);
        cyc("R7", 0, 1, 8'h00, '0, 4'hF, 1);
        // R9: unmapped word
        cyc("R9", 1, 0, 8'h40, 32'h1111_1111, 4'b0001, 0);
        cyc("R9", 0, 1, 8'h20, '0, 4'hF, 0);
        // R10: misaligned accesses
        cyc("R10", 1, 0, 8'h11, 32'h0000_AA00, 4'b0010, 0);
        cyc("R10", 1, 0, 8'h06, 32'h0077_0000, 4'b0100, 0);
        cyc("R10", 0, 1, 8'h04, '0, 4'hF, 0);
        cyc("R10", 0, 1, 8'h1B, '0, 4'b1000, 0);
        // R11: read gives enable without write valid
        cyc("R11", 0, 1, 8'h14, '0, 4'hF, 0);
        cyc("R11", 0, 0, 8'h14, '0, 4'hF, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule